// File: doc/BRIEF.md
# Time-Slot Multiplexed HDLC Receiver

This block pulls several independent HDLC channels out of one shared serial stream. The stream is divided into time slots. Each slot may carry its own HDLC channel. A single bit decoder serves every slot. It holds no per-channel state of its own. Each channel's state sits in a small internal context array. That state is swapped in when a slot starts and swapped back out when the slot ends.

The block runs on a system clock that is a multiple of the aggregate line rate. Upstream framing logic drives two inputs: the number of the slot on the line, and a strobe that marks the individual clock cycles carrying an HDLC bit. Within a slot, the decoder does three things. It hunts for the opening flag, removes inserted zeros and assembles bytes. Each completed byte leaves on a byte output, tagged with its slot number and with frame-start and frame-end markers. A run of seven ones inside a frame aborts it. A slot change that lands while a swap is still in progress raises an overrun pulse.

Top module: `hdlc_ts_rx`

## Requirements
- R1: A change of `slot_i` starts a context swap. Qualified bits in the first three cycles that carry the new slot number are ignored. From the fourth such cycle on, bits are decoded against that slot's saved context.
- R2: Each slot decodes as if it had a receiver of its own. Interleaving the bits of several slots in any slot order gives each slot the byte sequence it would give alone.
- R3: Outside a frame, the receiver hunts for the flag. The flag arrives on the wire as 0,1,1,1,1,1,1,0. Bits seen while hunting, including long runs of ones, produce no output. A flag opens a frame, and a flag shared between two frames both closes one and opens the next.
- R4: Inside a frame, a zero that follows five consecutive ones is discarded and is not counted as data.
- R5: Data bits are assembled least significant bit first: the first data bit received becomes bit 0. A byte is presented on `byte_o` with `byte_valid_o` high for one cycle. This happens in the cycle after the qualified bit that completes the following byte, or after the last bit of the closing flag.
- R6: `byte_sof_o` is high on the first byte of a frame. `byte_eof_o` is high on the last byte, which is released by a closing flag when the frame holds a whole number of bytes. A one-byte frame carries both markers.
- R7: Inside a frame, a seventh consecutive one raises `abort_o` for one cycle in the cycle after that bit. The byte still waiting to be released is dropped, no end marker is given, and the slot returns to hunting.
- R8: `evt_slot_o` gives the slot number that a byte or abort event belongs to.
- R9: A change of `slot_i` in the second or third cycle of a swap gives a one-cycle `overrun_o` pulse in the following cycle. The swap then retargets the newest slot, whose saved context stays intact. `overrun_o` never pulses otherwise.
- R10: After reset, all outputs are low and every slot context is hunting for a flag.
- R11: Cycles with `bit_en_i` low leave every context unchanged, whatever `bit_i` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, a multiple of the line rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_i | input | SLOT_W | Number of the time slot currently on the line |
| bit_en_i | input | 1 | High in a cycle whose `bit_i` is an HDLC bit |
| bit_i | input | 1 | Serial line bit |
| byte_valid_o | output | 1 | One-cycle strobe for a decoded byte |
| byte_o | output | 8 | Decoded byte, first-received bit in bit 0 |
| byte_sof_o | output | 1 | Byte is the first of its frame |
| byte_eof_o | output | 1 | Byte is the last of its frame |
| abort_o | output | 1 | One-cycle strobe: frame aborted by seven ones |
| evt_slot_o | output | SLOT_W | Slot of the current byte or abort event |
| overrun_o | output | 1 | One-cycle strobe: slot changed during a swap |

## Verification
The bench builds the block with its default of four slots, so the slot number is two bits wide. Four slots are enough for a random slot order in which every slot is suspended mid-frame, mid-byte and mid-stuffing sequence, and later resumed from its saved context. Two extra slot numbers remain free to change the target in the save cycle and again in the load cycle of one swap. Frames of one to six bytes, biased towards 0xFF and 0x7E, bring stuffed zeros, single-byte frames and aborts into every slot's context.

// File: rtl/hdlc_ts_pkg.sv
`timescale 1ns/1ps
package hdlc_ts_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);
    localparam int RUN_W     = 3;

    // lengths of runs of ones that change the decoder's behaviour
    localparam logic [RUN_W-1:0] RUN_STUFF = 3'd5;
    localparam logic [RUN_W-1:0] RUN_FLAG  = 3'd6;
    localparam logic [RUN_W-1:0] RUN_ABORT = 3'd7;

    // everything one channel needs between its slots
    typedef struct packed {
        logic [BYTE_W-1:0]    shreg;      // bits of the byte being assembled
        logic [BIT_CNT_W-1:0] nbits;      // bits already in shreg
        logic [RUN_W-1:0]     ones;       // current run of ones, saturating
        logic                 in_frame;   // a flag has been seen, no abort since
        logic                 first_pend; // next completed byte opens the frame
        logic [BYTE_W-1:0]    held;       // last completed byte, not yet released
        logic                 held_v;
        logic                 held_sof;
    } rx_ctx_t;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] data;
        logic              sof;
        logic              eof;
        logic              abort;
    } rx_evt_t;

    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,
        PH_SAVE = 2'd1,
        PH_LOAD = 2'd2
    } swap_ph_e;

endpackage

// File: rtl/hdlc_ts_bitstep.sv
`timescale 1ns/1ps
// Pure combinational step: one line bit applied to one channel context.
module hdlc_ts_bitstep
    import hdlc_ts_pkg::*;
(
    input  rx_ctx_t ctx_i,
    input  logic    bit_i,
    output rx_ctx_t ctx_o,
    output rx_evt_t evt_o
);

    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    rx_ctx_t           nxt;
    rx_evt_t           evt;
    logic              shift_en;
    logic [BYTE_W-1:0] sh_new;

    assign sh_new = {bit_i, ctx_i.shreg[BYTE_W-1:1]};

    always_comb begin
        nxt      = ctx_i;
        evt      = '0;
        shift_en = 1'b0;

        if (bit_i) begin
            if (ctx_i.ones == RUN_ABORT) begin
                nxt.ones = RUN_ABORT;
            end else if (ctx_i.ones == RUN_FLAG) begin
                // seventh one: abort whatever was open
                nxt.ones       = RUN_ABORT;
                evt.abort      = ctx_i.in_frame;
                nxt.in_frame   = 1'b0;
                nxt.held_v     = 1'b0;
                nxt.first_pend = 1'b0;
                nxt.nbits      = '0;
            end else begin
                nxt.ones = ctx_i.ones + 1'b1;
                shift_en = ctx_i.in_frame;
            end
        end else begin
            nxt.ones = '0;
            if (ctx_i.ones == RUN_FLAG) begin
                // flag complete; aligned frame releases its last byte
                if (ctx_i.in_frame && ctx_i.held_v && ctx_i.nbits == LAST_BIT) begin
                    evt.vld  = 1'b1;
                    evt.data = ctx_i.held;
                    evt.sof  = ctx_i.held_sof;
                    evt.eof  = 1'b1;
                end
                nxt.in_frame   = 1'b1;
                nxt.first_pend = 1'b1;
                nxt.held_v     = 1'b0;
                nxt.nbits      = '0;
            end else if (ctx_i.ones == RUN_STUFF && ctx_i.in_frame) begin
                nxt.ones = '0;  // inserted zero, dropped
            end else begin
                shift_en = ctx_i.in_frame;
            end
        end

        if (shift_en) begin
            nxt.shreg = sh_new;
            if (ctx_i.nbits == LAST_BIT) begin
                nxt.nbits = '0;
                if (ctx_i.held_v) begin
                    evt.vld  = 1'b1;
                    evt.data = ctx_i.held;
                    evt.sof  = ctx_i.held_sof;
                end
                nxt.held       = sh_new;
                nxt.held_v     = 1'b1;
                nxt.held_sof   = ctx_i.first_pend;
                nxt.first_pend = 1'b0;
            end else begin
                nxt.nbits = ctx_i.nbits + 1'b1;
            end
        end

        ctx_o = nxt;
        evt_o = evt;
    end

endmodule

// File: rtl/hdlc_ts_ctx_store.sv
`timescale 1ns/1ps
// Register array holding one context per slot; one write and one read port.
module hdlc_ts_ctx_store
    import hdlc_ts_pkg::*;
#(
    parameter int N_SLOTS = 4,
    parameter int SLOT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [SLOT_W-1:0] wr_slot_i,
    input  rx_ctx_t           wr_ctx_i,
    input  logic [SLOT_W-1:0] rd_slot_i,
    output rx_ctx_t           rd_ctx_o
);

    rx_ctx_t mem_q [N_SLOTS];
    rx_ctx_t mem_d [N_SLOTS];

    always_comb begin
        for (int s = 0; s < N_SLOTS; s++) begin
            mem_d[s] = mem_q[s];
            if (wr_en_i && wr_slot_i == SLOT_W'(s)) begin
                mem_d[s] = wr_ctx_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < N_SLOTS; s++) begin
                mem_q[s] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_ctx_o = mem_q[rd_slot_i];

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> mem_q[$past(wr_slot_i)] == $past(wr_ctx_i));

endmodule

// File: rtl/hdlc_ts_swap_ctl.sv
`timescale 1ns/1ps
// Sequences the fixed three-cycle swap: detect, save, load.
module hdlc_ts_swap_ctl
    import hdlc_ts_pkg::*;
#(
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot_i,
    output logic              proc_ok_o,
    output logic              save_en_o,
    output logic              load_en_o,
    output logic [SLOT_W-1:0] active_slot_o,
    output logic [SLOT_W-1:0] target_slot_o,
    output swap_ph_e          phase_o,
    output logic              overrun_o
);

    typedef struct packed {
        swap_ph_e          phase;
        logic [SLOT_W-1:0] active;
        logic [SLOT_W-1:0] target;
        logic              overrun;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic save_en, load_en;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.overrun = 1'b0;
        save_en       = 1'b0;
        load_en       = 1'b0;
        case (ctl_q.phase)
            PH_RUN: begin
                if (slot_i != ctl_q.active) begin
                    ctl_d.phase  = PH_SAVE;
                    ctl_d.target = slot_i;
                end
            end
            PH_SAVE: begin
                save_en     = 1'b1;
                ctl_d.phase = PH_LOAD;
                if (slot_i != ctl_q.target) begin
                    ctl_d.overrun = 1'b1;
                    ctl_d.target  = slot_i;
                end
            end
            PH_LOAD: begin
                if (slot_i != ctl_q.target) begin
                    ctl_d.overrun = 1'b1;
                    ctl_d.target  = slot_i;
                end else begin
                    load_en      = 1'b1;
                    ctl_d.active = ctl_q.target;
                    ctl_d.phase  = PH_RUN;
                end
            end
            default: ctl_d.phase = PH_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_RUN, active: '0, target: '0, overrun: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign proc_ok_o     = (ctl_q.phase == PH_RUN) && (slot_i == ctl_q.active);
    assign save_en_o     = save_en;
    assign load_en_o     = load_en;
    assign active_slot_o = ctl_q.active;
    assign target_slot_o = ctl_q.target;
    assign phase_o       = ctl_q.phase;
    assign overrun_o     = ctl_q.overrun;

    // R1
    save_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.phase == PH_SAVE |=> ctl_q.phase == PH_LOAD);

    // R9
    overrun_in_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.overrun |-> $past(ctl_q.phase) != PH_RUN);

endmodule

// File: rtl/hdlc_ts_rx.sv
`timescale 1ns/1ps
module hdlc_ts_rx
    import hdlc_ts_pkg::*;
#(
    parameter  int N_SLOTS = 4,
    localparam int SLOT_W  = $clog2(N_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              bit_en_i,
    input  logic              bit_i,
    output logic              byte_valid_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_sof_o,
    output logic              byte_eof_o,
    output logic              abort_o,
    output logic [SLOT_W-1:0] evt_slot_o,
    output logic              overrun_o
);

    typedef struct packed {
        rx_ctx_t           ctx;
        rx_evt_t           evt;
        logic [SLOT_W-1:0] evt_slot;
    } top_st_t;

    top_st_t           st_d, st_q;
    logic              proc_ok, save_en, load_en;
    logic [SLOT_W-1:0] active_slot, target_slot;
    swap_ph_e          phase;
    rx_ctx_t           rd_ctx, step_ctx;
    rx_evt_t           step_evt;

    hdlc_ts_swap_ctl #(.SLOT_W(SLOT_W)) swap_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .slot_i        (slot_i),
        .proc_ok_o     (proc_ok),
        .save_en_o     (save_en),
        .load_en_o     (load_en),
        .active_slot_o (active_slot),
        .target_slot_o (target_slot),
        .phase_o       (phase),
        .overrun_o     (overrun_o)
    );

    hdlc_ts_ctx_store #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (save_en),
        .wr_slot_i (active_slot),
        .wr_ctx_i  (st_q.ctx),
        .rd_slot_i (target_slot),
        .rd_ctx_o  (rd_ctx)
    );

    hdlc_ts_bitstep step_i (
        .ctx_i (st_q.ctx),
        .bit_i (bit_i),
        .ctx_o (step_ctx),
        .evt_o (step_evt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.evt = '0;
        if (load_en) begin
            st_d.ctx = rd_ctx;
        end else if (proc_ok && bit_en_i) begin
            st_d.ctx = step_ctx;
            st_d.evt = step_evt;
            if (step_evt.vld || step_evt.abort) begin
                st_d.evt_slot = active_slot;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_valid_o = st_q.evt.vld;
    assign byte_o       = st_q.evt.data;
    assign byte_sof_o   = st_q.evt.sof;
    assign byte_eof_o   = st_q.evt.eof;
    assign abort_o      = st_q.evt.abort;
    assign evt_slot_o   = st_q.evt_slot;

    // R1
    ctx_hold_in_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_SAVE |=> $stable(st_q.ctx));

    // R11
    evt_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_o || abort_o) |-> $past(bit_en_i));

    // R6
    eof_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_o && byte_eof_o) |-> !$past(bit_i));

    // R7
    abort_on_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> ($past(bit_i) && !byte_valid_o));

    // R8
    evt_slot_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_o || abort_o) |-> evt_slot_o == $past(slot_i));

endmodule

// File: tb/hdlc_ts_rx_tb_top.sv
`timescale 1ns/1ps
module hdlc_ts_rx_tb_top;

    localparam int N_SLOTS = 4;
    localparam int SLOT_W  = 2;

    typedef struct {
        logic [7:0] data;
        logic       sof;
        logic       eof;
        logic       abort;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [SLOT_W-1:0] slot_i = '0;
    logic              bit_en_i = 1'b0;
    logic              bit_i = 1'b0;
    logic              byte_valid_o, byte_sof_o, byte_eof_o, abort_o, overrun_o;
    logic [7:0]        byte_o;
    logic [SLOT_W-1:0] evt_slot_o;

    int   n_chk = 0;
    int   n_err = 0;
    int   spurious_ovr = 0;
    bit   ovr_expected = 1'b0;
    bit   mon_on = 1'b0;
    bit   finished = 1'b0;
    bit   bits_q [N_SLOTS][$];
    exp_t exp_q  [N_SLOTS][$];

    always #2.5 clk = ~clk;

    hdlc_ts_rx #(.N_SLOTS(N_SLOTS)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_i       (slot_i),
        .bit_en_i     (bit_en_i),
        .bit_i        (bit_i),
        .byte_valid_o (byte_valid_o),
        .byte_o       (byte_o),
        .byte_sof_o   (byte_sof_o),
        .byte_eof_o   (byte_eof_o),
        .abort_o      (abort_o),
        .evt_slot_o   (evt_slot_o),
        .overrun_o    (overrun_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    // ---------------- stream builder (encoder side) ----------------
    task automatic put_flag(input int s);
        bits_q[s].push_back(1'b0);
        for (int i = 0; i < 6; i++) bits_q[s].push_back(1'b1);
        bits_q[s].push_back(1'b0);
    endtask

    // LSB first, zero inserted after every fifth one (R4, R5)
    task automatic put_data(input int s, input logic [7:0] v, inout int run);
        for (int i = 0; i < 8; i++) begin
            bits_q[s].push_back(v[i]);
            if (v[i]) begin
                run++;
                if (run == 5) begin
                    bits_q[s].push_back(1'b0);
                    run = 0;
                end
            end else begin
                run = 0;
            end
        end
    endtask

    function automatic logic [7:0] pick_byte();
        case ($urandom_range(0, 3))
            0:       return 8'hFF;
            1:       return 8'h7E;
            default: return 8'($urandom);
        endcase
    endfunction

    task automatic add_frame(input int s, input int len, input bit aborted, input int kind);
        int   run = 0;
        exp_t e;
        put_flag(s);
        for (int i = 0; i < len; i++) begin
            logic [7:0] d;
            d = (kind == 1) ? 8'hFF : (kind == 2) ? 8'h7E : pick_byte();
            put_data(s, d, run);
            if (!aborted || i < len - 1) begin
                e.data = d; e.sof = (i == 0); e.eof = (!aborted && i == len - 1); e.abort = 1'b0;
                exp_q[s].push_back(e);
            end
        end
        if (aborted) begin
            for (int i = 0; i < 7; i++) bits_q[s].push_back(1'b1);  // R7
            e.data = '0; e.sof = 1'b0; e.eof = 1'b0; e.abort = 1'b1;
            exp_q[s].push_back(e);
        end else begin
            put_flag(s);
        end
    endtask

    function automatic bit bits_left();
        for (int s = 0; s < N_SLOTS; s++) if (bits_q[s].size() != 0) return 1'b1;
        return 1'b0;
    endfunction

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (overrun_o && !ovr_expected) spurious_ovr++;
            if (byte_valid_o || abort_o) begin
                int   si;
                exp_t e;
                si = int'(evt_slot_o);
                if (exp_q[si].size() == 0) begin
                    chk("R8 event on slot with nothing pending", {byte_valid_o, abort_o}, 0);
                end else begin
                    e = exp_q[si].pop_front();
                    chk("R7 abort strobe", abort_o, e.abort);
                    chk("R2 byte strobe", byte_valid_o, !e.abort);
                    if (!e.abort) begin
                        chk("R5 byte value", byte_o, e.data);
                        chk("R6 start marker", byte_sof_o, e.sof);
                        chk("R6 end marker", byte_eof_o, e.eof);
                    end
                end
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        int prev;
        void'($urandom(32'd7357));

        for (int s = 0; s < N_SLOTS; s++) begin
            // R3: long run of ones while hunting gives nothing
            for (int i = 0; i < 9; i++) bits_q[s].push_back(1'b1);
            case (s)
                0:       add_frame(s, 1, 1'b0, 0);  // R6 single byte frame
                1:       add_frame(s, 3, 1'b0, 1);  // R4 all-ones bytes
                2:       add_frame(s, 3, 1'b1, 0);  // R7 abort
                default: add_frame(s, 2, 1'b0, 2);  // R4 flag-like data
            endcase
            for (int f = 0; f < 6; f++) begin
                add_frame(s, $urandom_range(1, 6), ($urandom_range(0, 4) == 0), 0);
                if ($urandom_range(0, 1) == 1) put_flag(s);
            end
        end

        repeat (4) @(negedge clk);
        // R10: reset state
        chk("R10 byte strobe after reset", byte_valid_o, 0);
        chk("R10 abort after reset", abort_o, 0);
        chk("R10 overrun after reset", overrun_o, 0);
        chk("R10 slot after reset", evt_slot_o, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);

        prev = 0;
        while (bits_left()) begin
            int s;
            int len;
            do s = $urandom_range(0, N_SLOTS - 1); while (s == prev);
            len = 5 + $urandom_range(0, 8);
            for (int c = 0; c < len; c++) begin
                @(negedge clk);
                slot_i = SLOT_W'(s);
                if (c < 3) begin
                    // R1: qualified junk during the swap must be ignored
                    bit_en_i = 1'b1;
                    bit_i    = 1'($urandom);
                end else if (bits_q[s].size() != 0 && $urandom_range(0, 3) != 0) begin
                    bit_en_i = 1'b1;
                    bit_i    = bits_q[s].pop_front();
                end else begin
                    // R11: unqualified random bits have no effect
                    bit_en_i = 1'b0;
                    bit_i    = 1'($urandom);
                end
            end
            prev = s;
        end
        @(negedge clk);
        bit_en_i = 1'b0;
        repeat (6) @(negedge clk);

        // R9: target changes in the save cycle
        ovr_expected = 1'b1;
        slot_i = SLOT_W'((prev + 1) % N_SLOTS);
        @(negedge clk);
        slot_i = SLOT_W'((prev + 2) % N_SLOTS);
        @(negedge clk);
        chk("R9 overrun from save cycle", overrun_o, 1);
        @(negedge clk);
        chk("R9 overrun is one cycle", overrun_o, 0);
        repeat (4) @(negedge clk);

        // R9: target changes in the load cycle
        slot_i = SLOT_W'((prev + 3) % N_SLOTS);
        @(negedge clk);
        @(negedge clk);
        slot_i = SLOT_W'(prev);
        @(negedge clk);
        chk("R9 overrun from load cycle", overrun_o, 1);
        @(negedge clk);
        chk("R9 overrun is one cycle after load", overrun_o, 0);
        repeat (3) @(negedge clk);
        ovr_expected = 1'b0;

        // R9: newest slot resumes from its saved context (frame already open)
        begin
            int   run = 0;
            exp_t e;
            put_data(prev, 8'hA5, run);
            put_flag(prev);
            e.data = 8'hA5; e.sof = 1'b1; e.eof = 1'b1; e.abort = 1'b0;
            exp_q[prev].push_back(e);
            while (bits_q[prev].size() != 0) begin
                @(negedge clk);
                bit_en_i = 1'b1;
                bit_i    = bits_q[prev].pop_front();
            end
            @(negedge clk);
            bit_en_i = 1'b0;
        end
        repeat (6) @(negedge clk);

        for (int s = 0; s < N_SLOTS; s++) begin
            chk($sformatf("R2 slot %0d events left over", s), exp_q[s].size(), 0);
        end
        chk("R9 overrun outside a swap", spurious_ovr, 0);
        finish_run();
    end

endmodule